// File: doc/BRIEF.md
# Linked-List DMA Channel Controller

This block is one DMA channel that copies 32-bit words from a source address to a destination address over a word-wide memory master port. A request is held until the memory grants it. Software sets up the channel through nine word registers, then starts it by writing the control register with its enable bit set. The channel runs in one of two modes. In direct mode it performs the single transfer held in its registers. In descriptor mode it walks a chain of four-word descriptors in memory and performs the transfer each one describes.

Each transfer is split into chunks of a programmable number of words. The channel drops its memory request for at least one cycle between chunks, which gives other masters a window on the bus. Address masks confine the incrementing address bits, so a buffer can wrap. When a transfer ends, the channel raises a done flag and a pending interrupt bit. That bit can be routed to either of two interrupt outputs and is cleared by reading it.

The control machine has seven states:
- ST_IDLE: waiting for a start.
- ST_FETCH: reading descriptor words.
- ST_SETUP: sizing the next chunk, with the request low.
- ST_READ: reading one source word.
- ST_WRITE: writing that word to the destination.
- ST_LINK: deciding whether another descriptor follows.
- ST_FINISH: a one-cycle completion pulse.

Its transitions are:
- IDLE→FETCH on a start in descriptor mode, and IDLE→SETUP on a start in direct mode.
- FETCH→SETUP after the last descriptor word is granted.
- SETUP→READ when words remain, and SETUP→LINK when none remain.
- READ→WRITE on a grant.
- WRITE→READ while the chunk continues, WRITE→SETUP when a chunk ends with words left, and WRITE→LINK when the last word is written.
- LINK→FETCH when the descriptor is not marked end-of-list, and LINK→FINISH when it is, or in direct mode.
- FINISH→IDLE.

Top module: `ldma_channel`

## Requirements
- R1: After reset the memory request, both interrupt outputs, the busy bit (control bit 4) and the done bit (control bit 5) are 0. Both mask registers (index 3 source mask, index 5 destination mask) read 0xFFFFFFFF.
- R2: Register index 0 is control. Its bits are: 0 enable, 1 source increment, 2 destination increment, 3 descriptor mode, 4 busy (read-only), 5 done (read-only). A write with bit 0 set while idle starts the channel and clears done. Busy reads 1 from the cycle after that write until the transfer ends. At that point busy clears, done is set and enable clears.
- R3: In direct mode the channel copies the number of words given in register 1 bits [11:0]. It starts at the source address (index 2) and the destination address (index 4), and copies the words in order. After each word, each address whose increment bit is set advances by 4. An address whose increment bit is clear stays fixed.
- R4: Register 1 bits [24:16] set the chunk size. A chunk size of 0 means one chunk covering the whole transfer. The last chunk may be shorter than the others. Each chunk, and each descriptor fetch, is one unbroken assertion of the request.
- R5: After the last write of a chunk the request is low for at least one cycle.
- R6: A request that is not granted stays asserted in the next cycle, with the same address, write flag and write data.
- R7: When an address increments, bits where its mask register holds 0 keep their starting value.
- R8: In descriptor mode the channel fetches four words at the address in register 6: control, source, destination, next pointer. The descriptor control word holds the length in bits [11:0], source increment in bit 16, destination increment in bit 17 and end-of-list in bit 20. The channel runs that descriptor's transfer with the chunk size from register 1. It then continues at the next pointer, and sets done when the chain ends.
- R9: For a descriptor with end-of-list set, the channel does not read the next-pointer word and does not access the address it holds.
- R10: A length of 0 moves no data. In direct mode the channel finishes without any memory access. In descriptor mode the chain continues with the next descriptor.
- R11: Completion sets the pending bit, which is bit 0 of register 8. Interrupt output A equals pending AND bit 0 of register 7. Interrupt output B equals pending AND bit 1 of register 7. A read of register 8 returns pending and then clears it.
- R12: While the channel is busy, writes to registers 0 through 6 are ignored. This includes a second start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| reg_we | input | 1 | register write strobe |
| reg_re | input | 1 | register read strobe (clears pending on register 8) |
| reg_addr | input | 4 | register index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from reg_addr |
| mem_req | output | 1 | memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | byte address of the word |
| mem_wdata | output | 32 | write data |
| mem_gnt | input | 1 | grant; the access completes in the cycle it is high |
| mem_rdata | input | 32 | read data, valid in the granted cycle |
| irq_a | output | 1 | interrupt output A |
| irq_b | output | 1 | interrupt output B |

## Verification
The in-RTL properties watch the following on every cycle:
- the request stays stable while ungranted;
- the request drops after each chunk's last write;
- masked address bits do not move;
- the next-pointer word of an end-of-list descriptor is never fetched;
- the done and pending flags follow the completion pulse;
- register writes are locked out while busy.

Some behaviour only the bench scenarios can show, by comparing destination memory with an independently computed image:
- that the right data lands in the right words;
- that chunk counts match the programmed size;
- that a chain follows its links, skips zero-length entries, and never touches the dead pointer after end-of-list;
- that the interrupt routing and read-to-clear behave as stated.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int LEN_W      = 12;
    localparam int CHK_W      = 9;
    localparam int CHK_LSB    = 16;
    localparam int REG_AW     = 4;
    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int STEP_SH    = $clog2(DATA_W / 8);

    // register indices
    localparam logic [REG_AW-1:0] RI_CTRL  = 4'd0;
    localparam logic [REG_AW-1:0] RI_SIZE  = 4'd1;
    localparam logic [REG_AW-1:0] RI_SRC   = 4'd2;
    localparam logic [REG_AW-1:0] RI_SMASK = 4'd3;
    localparam logic [REG_AW-1:0] RI_DST   = 4'd4;
    localparam logic [REG_AW-1:0] RI_DMASK = 4'd5;
    localparam logic [REG_AW-1:0] RI_DESC  = 4'd6;
    localparam logic [REG_AW-1:0] RI_IMASK = 4'd7;
    localparam logic [REG_AW-1:0] RI_ISRC  = 4'd8;

    // control register bits
    localparam int CB_EN    = 0;
    localparam int CB_INC_S = 1;
    localparam int CB_INC_D = 2;
    localparam int CB_DESC  = 3;
    localparam int CB_BUSY  = 4;
    localparam int CB_DONE  = 5;

    // descriptor control word bits
    localparam int DC_INC_S = 16;
    localparam int DC_INC_D = 17;
    localparam int DC_EOL   = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_LINK,
        ST_FINISH
    } ldma_state_e;

    typedef struct packed {
        logic              inc_src;
        logic              inc_dst;
        logic              use_desc;
        logic [LEN_W-1:0]  len;
        logic [CHK_W-1:0]  chunk;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [ADDR_W-1:0] src_mask;
        logic [ADDR_W-1:0] dst_mask;
        logic [ADDR_W-1:0] desc_ptr;
    } ldma_cfg_t;
endpackage

// File: rtl/ldma_addr_step.sv
module ldma_addr_step #(
    parameter int AW    = 32,
    parameter int SHIFT = 2
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] mask,
    input  logic          inc,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STEP = AW'(1) << SHIFT;

    logic [AW-1:0] bumped;

    always_comb begin
        bumped = cur + STEP;
        nxt    = inc ? ((cur & ~mask) | (bumped & mask)) : cur;
    end
endmodule

// File: rtl/ldma_regs.sv
module ldma_regs
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ctrl_busy,
    input  logic              done_pulse,
    output ldma_cfg_t         cfg,
    output logic              start,
    output logic              irq_a,
    output logic              irq_b
);
    logic              en_q, inc_s_q, inc_d_q, desc_q, done_q, start_q, pend_q;
    logic [LEN_W-1:0]  len_q;
    logic [CHK_W-1:0]  chk_q;
    logic [ADDR_W-1:0] src_q, dst_q, smask_q, dmask_q, desc_ptr_q;
    logic [1:0]        imask_q;
    logic              busy_any;

    assign busy_any = ctrl_busy | start_q;
    assign start    = start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            inc_s_q    <= 1'b0;
            inc_d_q    <= 1'b0;
            desc_q     <= 1'b0;
            done_q     <= 1'b0;
            start_q    <= 1'b0;
            pend_q     <= 1'b0;
            len_q      <= '0;
            chk_q      <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            smask_q    <= '1;
            dmask_q    <= '1;
            desc_ptr_q <= '0;
            imask_q    <= '0;
        end else begin
            start_q <= 1'b0;
            if (reg_re && reg_addr == RI_ISRC) pend_q <= 1'b0;
            if (done_pulse) begin
                done_q <= 1'b1;
                en_q   <= 1'b0;
                pend_q <= 1'b1;
            end
            if (reg_we) begin
                unique case (reg_addr)
                    RI_CTRL: if (!busy_any) begin
                        en_q    <= reg_wdata[CB_EN];
                        inc_s_q <= reg_wdata[CB_INC_S];
                        inc_d_q <= reg_wdata[CB_INC_D];
                        desc_q  <= reg_wdata[CB_DESC];
                        if (reg_wdata[CB_EN]) begin
                            start_q <= 1'b1;
                            done_q  <= 1'b0;
                        end
                    end
                    RI_SIZE: if (!busy_any) begin
                        len_q <= reg_wdata[LEN_W-1:0];
                        chk_q <= reg_wdata[CHK_LSB +: CHK_W];
                    end
                    RI_SRC:   if (!busy_any) src_q      <= reg_wdata;
                    RI_SMASK: if (!busy_any) smask_q    <= reg_wdata;
                    RI_DST:   if (!busy_any) dst_q      <= reg_wdata;
                    RI_DMASK: if (!busy_any) dmask_q    <= reg_wdata;
                    RI_DESC:  if (!busy_any) desc_ptr_q <= reg_wdata;
                    RI_IMASK: imask_q <= reg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RI_CTRL: begin
                reg_rdata[CB_EN]    = en_q;
                reg_rdata[CB_INC_S] = inc_s_q;
                reg_rdata[CB_INC_D] = inc_d_q;
                reg_rdata[CB_DESC]  = desc_q;
                reg_rdata[CB_BUSY]  = busy_any;
                reg_rdata[CB_DONE]  = done_q;
            end
            RI_SIZE: begin
                reg_rdata[LEN_W-1:0]         = len_q;
                reg_rdata[CHK_LSB +: CHK_W]  = chk_q;
            end
            RI_SRC:   reg_rdata = src_q;
            RI_SMASK: reg_rdata = smask_q;
            RI_DST:   reg_rdata = dst_q;
            RI_DMASK: reg_rdata = dmask_q;
            RI_DESC:  reg_rdata = desc_ptr_q;
            RI_IMASK: reg_rdata[1:0] = imask_q;
            RI_ISRC:  reg_rdata[0] = pend_q;
            default:  reg_rdata = '0;
        endcase
    end

    always_comb begin
        cfg.inc_src  = inc_s_q;
        cfg.inc_dst  = inc_d_q;
        cfg.use_desc = desc_q;
        cfg.len      = len_q;
        cfg.chunk    = chk_q;
        cfg.src      = src_q;
        cfg.dst      = dst_q;
        cfg.src_mask = smask_q;
        cfg.dst_mask = dmask_q;
        cfg.desc_ptr = desc_ptr_q;
        irq_a        = pend_q & imask_q[0];
        irq_b        = pend_q & imask_q[1];
    end

    assert_done_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (done_q && !en_q));

    assert_pending_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> pend_q);

    assert_busy_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_any && reg_we && reg_addr == RI_SRC) |=> $stable(src_q));
endmodule

// File: rtl/ldma_ctrl.sv
module ldma_ctrl
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  ldma_cfg_t         cfg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done_pulse
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);
    localparam logic [IDX_W-1:0] IDX_DST  = IDX_W'(DESC_WORDS - 2);

    ldma_state_e       state, state_nx;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] ptr, next_ptr, src_cur, dst_cur, src_nx, dst_nx;
    logic [LEN_W-1:0]  remain, chunk_left, chunk_ext, chunk_size;
    logic              inc_s, inc_d, eol;
    logic [DATA_W-1:0] data_q;

    ldma_addr_step #(.AW(ADDR_W), .SHIFT(STEP_SH)) u_src_step (
        .cur(src_cur), .mask(cfg.src_mask), .inc(inc_s), .nxt(src_nx)
    );
    ldma_addr_step #(.AW(ADDR_W), .SHIFT(STEP_SH)) u_dst_step (
        .cur(dst_cur), .mask(cfg.dst_mask), .inc(inc_d), .nxt(dst_nx)
    );

    assign chunk_ext  = LEN_W'(cfg.chunk);
    assign chunk_size = (chunk_ext == '0 || chunk_ext >= remain) ? remain : chunk_ext;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = cfg.use_desc ? ST_FETCH : ST_SETUP;
            ST_FETCH:  if (mem_gnt && (idx == IDX_LAST || (idx == IDX_DST && eol)))
                           state_nx = ST_SETUP;
            ST_SETUP:  state_nx = (remain == '0) ? ST_LINK : ST_READ;
            ST_READ:   if (mem_gnt) state_nx = ST_WRITE;
            ST_WRITE:  if (mem_gnt) begin
                           if (chunk_left != LEN_W'(1)) state_nx = ST_READ;
                           else if (remain == LEN_W'(1)) state_nx = ST_LINK;
                           else state_nx = ST_SETUP;
                       end
            ST_LINK:   state_nx = eol ? ST_FINISH : ST_FETCH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx        <= '0;
            ptr        <= '0;
            next_ptr   <= '0;
            src_cur    <= '0;
            dst_cur    <= '0;
            remain     <= '0;
            chunk_left <= '0;
            inc_s      <= 1'b0;
            inc_d      <= 1'b0;
            eol        <= 1'b0;
            data_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    idx <= '0;
                    if (cfg.use_desc) begin
                        ptr <= cfg.desc_ptr;
                        eol <= 1'b0;
                    end else begin
                        src_cur <= cfg.src;
                        dst_cur <= cfg.dst;
                        remain  <= cfg.len;
                        inc_s   <= cfg.inc_src;
                        inc_d   <= cfg.inc_dst;
                        eol     <= 1'b1;
                    end
                end
                ST_FETCH: if (mem_gnt) begin
                    idx <= idx + IDX_W'(1);
                    unique case (idx)
                        2'd0: begin
                            remain <= mem_rdata[LEN_W-1:0];
                            inc_s  <= mem_rdata[DC_INC_S];
                            inc_d  <= mem_rdata[DC_INC_D];
                            eol    <= mem_rdata[DC_EOL];
                        end
                        2'd1:    src_cur  <= mem_rdata;
                        2'd2:    dst_cur  <= mem_rdata;
                        default: next_ptr <= mem_rdata;
                    endcase
                end
                ST_SETUP: if (remain != '0) chunk_left <= chunk_size;
                ST_READ:  if (mem_gnt) data_q <= mem_rdata;
                ST_WRITE: if (mem_gnt) begin
                    src_cur    <= src_nx;
                    dst_cur    <= dst_nx;
                    remain     <= remain - LEN_W'(1);
                    chunk_left <= chunk_left - LEN_W'(1);
                end
                ST_LINK: begin
                    ptr <= next_ptr;
                    idx <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = dst_cur;
        mem_wdata  = data_q;
        busy       = (state != ST_IDLE);
        done_pulse = 1'b0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr + (ADDR_W'(idx) << STEP_SH);
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_cur;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_FINISH: done_pulse = 1'b1;
            default: ;
        endcase
    end

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    assert_chunk_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && mem_gnt && chunk_left == LEN_W'(1)) |=> !mem_req);

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && mem_gnt) |=>
        ((((src_cur ^ $past(src_cur)) & ~cfg.src_mask) == '0) &&
         (((dst_cur ^ $past(dst_cur)) & ~cfg.dst_mask) == '0)));

    assert_no_link_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && idx == IDX_LAST) |-> !eol);
endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
    import ldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq_a,
    output logic              irq_b
);
    ldma_cfg_t cfg;
    logic      start, busy, done_pulse;

    ldma_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ctrl_busy  (busy),
        .done_pulse (done_pulse),
        .cfg        (cfg),
        .start      (start),
        .irq_a      (irq_a),
        .irq_b      (irq_b)
    );

    ldma_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg        (cfg),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done_pulse (done_pulse)
    );
endmodule

// File: tb/ldma_channel_tb.sv
`timescale 1ns/1ps
module ldma_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_gnt, irq_a, irq_b;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #4 clk = ~clk;   // 125 MHz

    ldma_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    // memory model: 256 words, grant stalls every third cycle
    logic [31:0] mem [0:255];
    int          stall_cnt = 0;
    logic        gnt_ok = 1'b1;
    assign mem_gnt   = mem_req & gnt_ok;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(negedge clk) begin
        stall_cnt <= stall_cnt + 1;
        gnt_ok    <= (stall_cnt % 3) != 0;
    end

    int          rises = 0, wild = 0, watch_hits = 0, hold_err = 0, cycles = 0;
    logic        prev_req = 1'b0, hold_pend = 1'b0;
    logic [31:0] hold_addr = '0, watch_addr = 32'hFFFF_FFF0;
    int          checks = 0, errors = 0;

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (hold_pend && (!mem_req || mem_addr != hold_addr)) hold_err = hold_err + 1;
        hold_pend = mem_req && !mem_gnt;
        hold_addr = mem_addr;
        if (mem_req && !prev_req) rises = rises + 1;
        prev_req = mem_req;
        if (mem_req && mem_addr[31:10] != '0) wild = wild + 1;
        if (mem_req && !mem_we && mem_addr == watch_addr) watch_hits = watch_hits + 1;
        if (mem_req && mem_we && mem_gnt) mem[mem_addr[9:2]] <= mem_wdata;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(4'd0, v);
            if (!v[4]) break;
        end
    endtask

    function automatic logic [31:0] pat(input int w);
        return 32'hA500_0000 + w * 32'h0101_0011;
    endfunction

    task automatic fill();
        for (int w = 0; w < 160; w++) mem[w] = (w < 64) ? pat(w) : 32'h0;
    endtask

    task automatic clear_counts();
        @(negedge clk);
        rises = 0; wild = 0; watch_hits = 0;
    endtask

    // {len[11:0], chunk[8:0], inc_src, inc_dst, expected request bursts[5:0]}
    localparam logic [28:0] VEC [0:6] = '{
        {12'd2, 9'd0, 1'b1, 1'b1, 6'd1},
        {12'd6, 9'd3, 1'b1, 1'b1, 6'd2},
        {12'd7, 9'd3, 1'b1, 1'b1, 6'd3},
        {12'd5, 9'd1, 1'b1, 1'b1, 6'd5},
        {12'd4, 9'd0, 1'b1, 1'b0, 6'd1},
        {12'd3, 9'd2, 1'b0, 1'b1, 6'd2},
        {12'd1, 9'd9, 1'b1, 1'b1, 6'd1}
    };

    logic [31:0] expd [0:63];
    logic [31:0] v;
    int          bad;

    task automatic compare_dst(input string req);
        bad = 0;
        for (int k = 0; k < 64; k++)
            if (mem[64 + k] !== expd[k]) begin
                if (bad == 0) check(1'b0, req, mem[64 + k], expd[k]);
                bad++;
            end
        if (bad == 0) check(1'b1, req, 0, 0);
    endtask

    initial begin
        for (int w = 0; w < 256; w++) mem[w] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!mem_req, "R1 req", {31'd0, mem_req}, 0);
        check(!irq_a && !irq_b, "R1 irq", {30'd0, irq_a, irq_b}, 0);
        rst_n = 1'b1;
        rd(4'd0, v);  check(v[5:4] == 2'b00, "R1 busy/done", v, 0);
        rd(4'd3, v);  check(v == 32'hFFFF_FFFF, "R1 src mask", v, 32'hFFFF_FFFF);
        rd(4'd5, v);  check(v == 32'hFFFF_FFFF, "R1 dst mask", v, 32'hFFFF_FFFF);

        // table walk: direct mode R3, R4, R5
        for (int t = 0; t < 7; t++) begin
            logic [11:0] len  = VEC[t][28:17];
            logic [8:0]  chk  = VEC[t][16:8];
            logic        is   = VEC[t][7];
            logic        id   = VEC[t][6];
            logic [5:0]  nbur = VEC[t][5:0];
            fill();
            for (int k = 0; k < 64; k++) expd[k] = '0;
            for (int i = 0; i < int'(len); i++)
                expd[id ? i : 0] = pat(16 + (is ? i : 0));
            wr(4'd1, {7'd0, chk, 4'd0, len});
            wr(4'd2, 32'h40);
            wr(4'd4, 32'h100);
            clear_counts();
            wr(4'd0, {29'd0, id, is, 1'b1});
            #1 check(reg_rdata[4], "R2 busy after start", reg_rdata, 32'h10);
            wait_idle();
            compare_dst("R3 direct copy data");
            check(rises == int'(nbur), "R4 R5 chunk bursts", rises, {26'd0, nbur});
            rd(4'd0, v);
            check(v[5] && !v[0], "R2 done set, enable cleared", v, 32'h20);
        end

        // R7 mask wrap, R11 interrupt A
        rd(4'd8, v);
        fill();
        for (int k = 0; k < 64; k++) expd[k] = (k < 6) ? pat(16 + (k % 4)) : 32'h0;
        wr(4'd3, 32'h0000_000C);
        wr(4'd1, 32'd6);
        wr(4'd7, 32'd1);
        wr(4'd0, 32'h7);
        wait_idle();
        compare_dst("R7 masked source wrap");
        check(irq_a && !irq_b, "R11 irq A routed", {30'd0, irq_a, irq_b}, 32'h2);
        rd(4'd8, v);  check(v[0], "R11 pending read", v, 1);
        #1 check(!irq_a, "R11 read clears", {31'd0, irq_a}, 0);
        rd(4'd8, v);  check(!v[0], "R11 second read", v, 0);
        wr(4'd3, 32'hFFFF_FFFF);

        // R10 direct zero length, R11 interrupt B
        wr(4'd7, 32'd2);
        wr(4'd1, 32'd0);
        clear_counts();
        wr(4'd0, 32'h7);
        wait_idle();
        check(rises == 0, "R10 zero length no access", rises, 0);
        rd(4'd0, v);  check(v[5], "R10 zero length done", v, 32'h20);
        check(irq_b && !irq_a, "R11 irq B routed", {30'd0, irq_a, irq_b}, 32'h1);
        rd(4'd8, v);
        wr(4'd7, 32'd0);

        // R8 R9 descriptor chain
        fill();
        for (int k = 0; k < 64; k++) expd[k] = (k < 10) ? pat(16 + k) : 32'h0;
        mem[200] = 32'h0003_0006; mem[201] = 32'h40; mem[202] = 32'h100; mem[203] = 32'h340;
        mem[208] = 32'h0013_0004; mem[209] = 32'h58; mem[210] = 32'h118;
        mem[211] = 32'hDEAD_DEAD;
        wr(4'd1, 32'd2 << 16);
        wr(4'd6, 32'h320);
        clear_counts();
        watch_addr = 32'h34C;
        wr(4'd0, 32'h9);
        wait_idle();
        compare_dst("R8 chain data");
        check(rises == 7, "R8 R4 chain bursts", rises, 7);
        check(watch_hits == 0, "R9 end-of-list link word unread", watch_hits, 0);
        check(wild == 0, "R9 dead pointer not followed", wild, 0);
        rd(4'd0, v);  check(v[5] && !v[4], "R8 done after chain", v, 32'h20);

        // R10 zero-length descriptor inside a chain
        fill();
        for (int k = 0; k < 64; k++) expd[k] = '0;
        expd[32] = pat(16); expd[33] = pat(17);
        mem[216] = 32'h0003_0000; mem[217] = 32'h40; mem[218] = 32'h100; mem[219] = 32'h380;
        mem[224] = 32'h0013_0002; mem[225] = 32'h40; mem[226] = 32'h180; mem[227] = 32'h0;
        wr(4'd1, 32'd0);
        wr(4'd6, 32'h360);
        wr(4'd0, 32'h9);
        wait_idle();
        compare_dst("R10 empty descriptor skipped");

        // R12 writes while busy ignored
        fill();
        wr(4'd1, 32'd40);
        wr(4'd2, 32'h40);
        wr(4'd4, 32'h100);
        clear_counts();
        wr(4'd0, 32'h7);
        wr(4'd2, 32'h200);
        wr(4'd0, 32'h9);
        rd(4'd2, v);  check(v == 32'h40, "R12 source locked while busy", v, 32'h40);
        rd(4'd0, v);  check(v[3:0] == 4'h7, "R12 control locked while busy", v, 32'h7);
        wait_idle();
        repeat (10) @(negedge clk);
        rd(4'd0, v);  check(!v[4], "R12 no second start", v, 0);
        check(rises == 1, "R12 single run", rises, 1);

        // R6 request stability observed throughout
        check(hold_err == 0, "R6 ungranted request held", hold_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule